// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block keeps an 8-bit accumulation count driven by one external, asynchronous input line. It can run in two modes. In event mode the count advances by one for every transition of the chosen direction on that line. In gated mode the line acts as a window: while it sits at the chosen level, each pulse on a clock-enable tick input adds one to the count. The tick comes from the chip's main clock divider, and in a typical build it arrives once every 64 system clocks. Gated mode therefore measures how long the input stays at that level.

Software can load the count at any time. A load takes precedence over an increment in the same cycle. Two sticky flags report events. The overflow flag is set when the count wraps from all ones to zero. The input flag is set by each counted edge in event mode, and by the trailing edge of the gating window in gated mode. Each flag has its own clear strobe and its own interrupt enable. A master enable freezes counting and flag setting without disturbing the stored count.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count is 0x00 and both flags and both interrupt requests are low.
- R2: With `mode_i`=0 (event) and `en_i`=1, the count rises by one for each rising edge of `pin_i` when `pol_i`=1, and for each falling edge when `pol_i`=0. An edge of the other direction leaves the count unchanged.
- R3: With `mode_i`=1 (gated) and `en_i`=1, each `tick_i` pulse adds one to the count while the synchronized input equals `pol_i`. A tick that arrives while the input is at the other level has no effect.
- R4: `edge_flag_o` is set by every counted edge in event mode. In gated mode it is set by the edge that ends the active level (falling edge when `pol_i`=1, rising edge when `pol_i`=0), and not while the level is still active.
- R5: An increment from 0xFF gives 0x00 and sets `ovf_flag_o`. The overflow flag is set by nothing else.
- R6: While `en_i`=0, edges and ticks change neither the count nor either flag.
- R7: `wr_i` loads `wr_data_i` into the count on the next clock, whatever the state of `en_i`. In a cycle where an increment is also due, the loaded value wins.
- R8: A flag stays set until its clear strobe (`ovf_clr_i`, `edge_clr_i`) is pulsed. A clear affects only its own flag. A set in the same cycle as a clear wins.
- R9: `ovf_irq_o` and `edge_irq_o` are high exactly when their flag is set and the matching enable (`ovf_ie_i`, `edge_ie_i`) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous external input |
| tick_i | input | 1 | Accumulation clock enable from the divider chain |
| en_i | input | 1 | Master counting enable |
| mode_i | input | 1 | 0 = event counting, 1 = gated accumulation |
| pol_i | input | 1 | Edge direction (1 rising) or active level (1 high) |
| wr_i | input | 1 | Load strobe for the count |
| wr_data_i | input | 8 | Value to load |
| count_o | output | 8 | Current count |
| ovf_clr_i | input | 1 | Clear strobe for the overflow flag |
| edge_clr_i | input | 1 | Clear strobe for the input flag |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| edge_ie_i | input | 1 | Input-flag interrupt enable |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| edge_flag_o | output | 1 | Sticky input flag |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| edge_irq_o | output | 1 | Input-flag interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit count and a two-stage input synchronizer. The count is short, so preloading values such as 0xFD or 0xFE lets the wrap to zero and the overflow flag appear after only a few edges or ticks. The two-stage synchronizer keeps the delay from pin to count at three clocks, which is short enough that each pulse and gating window in the stimulus fits in a handful of cycles.

// File: rtl/pa_pkg.sv
package pa_pkg;

    typedef enum logic {
        PA_EVENT = 1'b0,
        PA_GATED = 1'b1
    } pa_mode_e;

    localparam int FLAG_OVF  = 0;
    localparam int FLAG_EDGE = 1;
    localparam int NUM_FLAGS = 2;

endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_q, st_d;
    logic [STAGES-1:0] shifted_w;

    generate
        if (STAGES == 1) begin : g_single
            assign shifted_w = pin_i;
        end else begin : g_multi
            assign shifted_w = {st_q.chain[STAGES-2:0], pin_i};
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.chain = shifted_w;
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[STAGES-1];
    assign rise_o  = st_q.chain[STAGES-1] & ~st_q.prev;
    assign fall_o  = ~st_q.chain[STAGES-1] & st_q.prev;

endmodule

// File: rtl/pa_decode.sv
module pa_decode
    import pa_pkg::*;
(
    input  logic     en_i,
    input  pa_mode_e mode_i,
    input  logic     pol_i,
    input  logic     tick_i,
    input  logic     level_i,
    input  logic     rise_i,
    input  logic     fall_i,
    output logic     inc_o,
    output logic     edge_set_o
);

    logic lead_w;
    logic trail_w;

    always_comb begin
        lead_w     = pol_i ? rise_i : fall_i;
        trail_w    = pol_i ? fall_i : rise_i;
        inc_o      = 1'b0;
        edge_set_o = 1'b0;
        if (en_i) begin
            unique case (mode_i)
                PA_EVENT: begin
                    inc_o      = lead_w;
                    edge_set_o = lead_w;
                end
                PA_GATED: begin
                    inc_o      = tick_i & (level_i == pol_i);
                    edge_set_o = trail_w;
                end
                default: begin
                    inc_o      = 1'b0;
                    edge_set_o = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] count_o,
    output logic             wrap_o
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } cnt_t;

    cnt_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        if (wr_i) begin
            st_d.count = wr_data_i;
        end else if (inc_i) begin
            st_d.count = st_q.count + ONE;
            wrap_o     = (st_q.count == ALL_ONES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

endmodule

// File: rtl/pa_flags.sv
module pa_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] ie_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] irq_o
);

    typedef struct packed {
        logic [N-1:0] flag;
    } flg_t;

    flg_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (set_i[i]) begin
                st_d.flag[i] = 1'b1;
            end else if (clr_i[i]) begin
                st_d.flag[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    generate
        for (genvar g = 0; g < N; g++) begin : g_irq
            assign irq_o[g] = st_q.flag[g] & ie_i[g];
        end
    endgenerate

endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pa_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             mode_i,
    input  logic             pol_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    input  logic             ovf_clr_i,
    input  logic             edge_clr_i,
    input  logic             ovf_ie_i,
    input  logic             edge_ie_i,
    output logic             ovf_flag_o,
    output logic             edge_flag_o,
    output logic             ovf_irq_o,
    output logic             edge_irq_o
);

    logic level_w, rise_w, fall_w;
    logic inc_w, edge_set_w, wrap_w;
    logic [NUM_FLAGS-1:0] set_w, clr_w, ie_w, flag_w, irq_w;
    pa_mode_e mode_w;

    assign mode_w = pa_mode_e'(mode_i);

    pa_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .level_o (level_w),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    pa_decode u_decode (
        .en_i       (en_i),
        .mode_i     (mode_w),
        .pol_i      (pol_i),
        .tick_i     (tick_i),
        .level_i    (level_w),
        .rise_i     (rise_w),
        .fall_i     (fall_w),
        .inc_o      (inc_w),
        .edge_set_o (edge_set_w)
    );

    pa_counter #(.WIDTH(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (inc_w),
        .wr_i      (wr_i),
        .wr_data_i (wr_data_i),
        .count_o   (count_o),
        .wrap_o    (wrap_w)
    );

    always_comb begin
        set_w            = '0;
        clr_w            = '0;
        ie_w             = '0;
        set_w[FLAG_OVF]  = wrap_w;
        set_w[FLAG_EDGE] = edge_set_w;
        clr_w[FLAG_OVF]  = ovf_clr_i;
        clr_w[FLAG_EDGE] = edge_clr_i;
        ie_w[FLAG_OVF]   = ovf_ie_i;
        ie_w[FLAG_EDGE]  = edge_ie_i;
    end

    pa_flags #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_w),
        .clr_i  (clr_w),
        .ie_i   (ie_w),
        .flag_o (flag_w),
        .irq_o  (irq_w)
    );

    assign ovf_flag_o  = flag_w[FLAG_OVF];
    assign edge_flag_o = flag_w[FLAG_EDGE];
    assign ovf_irq_o   = irq_w[FLAG_OVF];
    assign edge_irq_o  = irq_w[FLAG_EDGE];

endmodule

// File: rtl/pulse_accum_chk.sv
module pulse_accum_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             en_i,
    input logic             mode_i,
    input logic             wr_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_flag_o,
    input logic             edge_flag_o,
    input logic             ovf_irq_o,
    input logic             edge_irq_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R1: count leaves zero only after reset has been released
    p_reset_zero_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> count_o == '0);

    // R2: the count moves by one step at most per clock
    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + ONE));

    // R3: in gated mode nothing but a tick advances the count
    p_gated_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && !tick_i && !wr_i) |=> count_o == $past(count_o));

    // R5: the overflow flag rises only on a wrap to zero
    p_ovf_only_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag_o) |-> (count_o == '0));

    // R6: a disabled block holds its count
    p_hold_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !wr_i) |=> count_o == $past(count_o));

    // R6: a disabled block raises no flag
    p_no_flag_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !$rose(edge_flag_o) && !$rose(ovf_flag_o));

    // R7: a load always lands, even against an increment
    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> count_o == $past(wr_data_i));

    // R9: no request without its flag
    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_irq_o || ovf_flag_o) && (!edge_irq_o || edge_flag_o));

endmodule

bind pulse_accum pulse_accum_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .en_i        (en_i),
    .mode_i      (mode_i),
    .wr_i        (wr_i),
    .wr_data_i   (wr_data_i),
    .count_o     (count_o),
    .ovf_flag_o  (ovf_flag_o),
    .edge_flag_o (edge_flag_o),
    .ovf_irq_o   (ovf_irq_o),
    .edge_irq_o  (edge_irq_o)
);

// File: tb/pulse_accum_test.sv
module pulse_accum_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 6;

    // {mode, pol, init[7:0], n[7:0], expected[7:0], expected_ovf}
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 8'h00, 8'd5, 8'h05, 1'b0},
        {1'b0, 1'b0, 8'h10, 8'd3, 8'h13, 1'b0},
        {1'b0, 1'b1, 8'hFE, 8'd3, 8'h01, 1'b1},
        {1'b1, 1'b1, 8'h00, 8'd7, 8'h07, 1'b0},
        {1'b1, 1'b0, 8'h20, 8'd4, 8'h24, 1'b0},
        {1'b1, 1'b1, 8'hFD, 8'd4, 8'h01, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_i = 1'b0, tick_i = 1'b0, en_i = 1'b0, mode_i = 1'b0, pol_i = 1'b1;
    logic wr_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic ovf_clr_i = 1'b0, edge_clr_i = 1'b0, ovf_ie_i = 1'b0, edge_ie_i = 1'b0;
    logic [7:0] count_o;
    logic ovf_flag_o, edge_flag_o, ovf_irq_o, edge_irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_accum uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .tick_i(tick_i),
        .en_i(en_i), .mode_i(mode_i), .pol_i(pol_i),
        .wr_i(wr_i), .wr_data_i(wr_data_i), .count_o(count_o),
        .ovf_clr_i(ovf_clr_i), .edge_clr_i(edge_clr_i),
        .ovf_ie_i(ovf_ie_i), .edge_ie_i(edge_ie_i),
        .ovf_flag_o(ovf_flag_o), .edge_flag_o(edge_flag_o),
        .ovf_irq_o(ovf_irq_o), .edge_irq_o(edge_irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic m, input logic p, input logic [7:0] init);
        en_i   = 1'b0;
        mode_i = m;
        pol_i  = p;
        pin_i  = ~p;
        cycles(6);
        wr_i = 1'b1; wr_data_i = init;
        cycles(1);
        wr_i = 1'b0;
        ovf_clr_i = 1'b1; edge_clr_i = 1'b1;
        cycles(1);
        ovf_clr_i = 1'b0; edge_clr_i = 1'b0;
        en_i = 1'b1;
        cycles(1);
    endtask

    task automatic event_pulses(input int n);
        for (int k = 0; k < n; k++) begin
            pin_i = pol_i;  cycles(4);
            pin_i = ~pol_i; cycles(4);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick_i = 1'b1; cycles(1);
            tick_i = 1'b0; cycles(2);
        end
    endtask

    task automatic gated_window(input int n);
        pin_i = pol_i; cycles(4);
        ticks(n);
        pin_i = ~pol_i; cycles(5);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 to R9: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        cycles(5);
        // R1: reset state
        check("R1 count",    count_o, 8'h00);
        check("R1 ovf flag", {7'b0, ovf_flag_o}, 8'h00);
        check("R1 edge flag",{7'b0, edge_flag_o}, 8'h00);
        check("R1 irqs",     {6'b0, ovf_irq_o, edge_irq_o}, 8'h00);
        rst_n = 1'b1;
        cycles(2);
        check("R1 count after release", count_o, 8'h00);

        // Table walk: R2 R3 R4 R5 R9
        ovf_ie_i = 1'b1; edge_ie_i = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            logic       m, p, eo;
            logic [7:0] init, n, ex;
            {m, p, init, n, ex, eo} = VEC[i];
            setup(m, p, init);
            if (m) gated_window(int'(n));
            else   event_pulses(int'(n));
            check(m ? "R3 gated count" : "R2 event count", count_o, ex);
            check("R5 overflow flag", {7'b0, ovf_flag_o}, {7'b0, eo});
            check("R4 input flag",    {7'b0, edge_flag_o}, 8'h01);
            check("R9 irq follows flags", {6'b0, ovf_irq_o, edge_irq_o}, {6'b0, eo, 1'b1});
        end

        // R6: disabled, edges and ticks ignored
        setup(1'b0, 1'b1, 8'h40);
        en_i = 1'b0;
        event_pulses(3);
        check("R6 count held", count_o, 8'h40);
        check("R6 no input flag", {7'b0, edge_flag_o}, 8'h00);
        mode_i = 1'b1;
        gated_window(2);
        check("R6 gated count held", count_o, 8'h40);

        // R2: opposite edge ignored
        setup(1'b0, 1'b1, 8'h00);
        pin_i = 1'b1; cycles(5);
        check("R2 rising counted", count_o, 8'h01);
        pin_i = 1'b0; cycles(5);
        check("R2 falling ignored", count_o, 8'h01);

        // R3: ticks outside the active level ignored
        setup(1'b1, 1'b1, 8'h30);
        ticks(3);
        check("R3 inactive ticks ignored", count_o, 8'h30);

        // R4: no input flag until the window ends
        pin_i = 1'b1; cycles(4);
        ticks(2);
        check("R4 flag low inside window", {7'b0, edge_flag_o}, 8'h00);
        check("R3 active ticks counted", count_o, 8'h32);

        // R7: load wins over a coincident tick
        wr_data_i = 8'h77; wr_i = 1'b1; tick_i = 1'b1;
        cycles(1);
        wr_i = 1'b0; tick_i = 1'b0;
        check("R7 write beats increment", count_o, 8'h77);
        ticks(1);
        check("R7 counting resumes", count_o, 8'h78);
        pin_i = 1'b0; cycles(5);
        check("R4 trailing edge sets flag", {7'b0, edge_flag_o}, 8'h01);

        // R7: load while disabled
        en_i = 1'b0;
        wr_data_i = 8'hA5; wr_i = 1'b1; cycles(1); wr_i = 1'b0;
        check("R7 write while disabled", count_o, 8'hA5);
        en_i = 1'b1;

        // R8 / R9: sticky flags, separate clears, enables gate requests
        setup(1'b0, 1'b1, 8'hFF);
        event_pulses(1);
        cycles(10);
        check("R8 flags sticky", {6'b0, ovf_flag_o, edge_flag_o}, 8'h03);
        ovf_clr_i = 1'b1; cycles(1); ovf_clr_i = 1'b0;
        check("R8 ovf clear only", {6'b0, ovf_flag_o, edge_flag_o}, 8'h01);
        edge_ie_i = 1'b0;
        cycles(1);
        check("R9 irq masked", {6'b0, ovf_irq_o, edge_irq_o}, 8'h00);
        edge_clr_i = 1'b1; cycles(1); edge_clr_i = 1'b0;
        check("R8 edge clear", {7'b0, edge_flag_o}, 8'h00);

        done = 1'b1;
        finish_run();
    end

endmodule